// File: doc/BRIEF.md
# Inter-Processor Interrupt Command Register

This block holds the command that a processor uses to send an interrupt message to other processors. The command is a 64-bit register split into two 32-bit words on a plain register port. The high word carries an 8-bit destination ID. The low word carries the vector, delivery mode, destination mode, trigger mode, level assert/deassert bit and a destination shorthand. A write to the low word is the only thing that starts a send.

At that write the block takes the low-word fields and the destination ID currently held in the high word. It presents them as one message on an outbound valid/ready port. Software must write the high word first and then the low word. It then polls the delivery-status bit of the low word until it reads 0.

A start-up style message uses the vector byte to carry a page index. The block passes that byte through unchanged. Bits 17:16 of the low word report the remote-read status supplied from outside. The block only mirrors this status.

Top module: `ipi_cmd_reg`

## Requirements
- R1: After reset, `msg_valid` and `busy_err` are 0, the high word reads 0, and the low word reads 0 except bits 17:16, which show `rrd_status`.
- R2: A write to byte offset 0x310 stores bits 31:24 as the destination ID. That word reads back with the ID in bits 31:24 and zeros in bits 23:0.
- R3: A write to byte offset 0x300 while idle raises `msg_valid` on the next clock edge. The message carries the following fields, taken from the written word: vector from bits 7:0, delivery mode from bits 10:8, destination mode from bit 11, level (1 = assert) from bit 14, trigger (1 = level) from bit 15 and shorthand from bits 19:18. It also carries the destination ID held at the time of the write.
- R4: Delivery status (low word bit 12) reads 1 from the edge that accepts the low write until the edge where `msg_valid` and `msg_ready` are both 1. On that edge both the status bit and `msg_valid` return to 0.
- R5: While `msg_valid` is 1 and `msg_ready` is 0, `msg_valid` and every message field keep their values.
- R6: A low-word write while delivery status is 1 is ignored: no second message is sent, and the low word reads back unchanged. The same write sets `busy_err`, which then stays 1 until reset.
- R7: A high-word write while a message is pending does not alter the message in flight. It does set the destination ID of the next message.
- R8: Low word bits 17:16 always read the `rrd_status` input (00 invalid, 01 in progress, 10 valid). Writes to those bits have no effect.
- R9: All four shorthand codes pass to `msg_shorthand` unchanged: 00 uses the destination field, 01 self only, 10 all including self, 11 all excluding self. A level bit of 0 (deassert) is also passed through.
- R10: A write to any other offset changes nothing and starts no message. Reads of other offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| rrd_status | input | 2 | Remote-read status mirrored into low word bits 17:16 |
| msg_valid | output | 1 | Outbound message is present |
| msg_ready | input | 1 | Receiver accepts the message |
| msg_vector | output | 8 | Vector or start-up page index |
| msg_dmode | output | 3 | Delivery mode |
| msg_dest_logical | output | 1 | Destination mode, 1 = logical |
| msg_trig_level | output | 1 | Trigger mode, 1 = level |
| msg_level_assert | output | 1 | 1 = assert, 0 = deassert |
| msg_shorthand | output | 2 | Destination shorthand |
| msg_dest_id | output | 8 | Destination ID |
| busy_err | output | 1 | Sticky flag for a low write refused while busy |

## Verification
If the busy state is wrong, the error shows at the ports within one cycle. The status bit and `msg_valid` would disagree, the bit would stay set after the handshake edge, or `busy_err` would be raised by a refused write that should have been accepted. If the captured message is wrong, the mismatch is visible on the outbound fields in the cycle after the low write. A stale or overwritten destination ID shows only on the next accepted message, which is why the bench changes the high word while a message is stalled. A scoreboard compares each handshaken message with one predicted from the written words, so a lost or duplicated send is seen as a queue underflow or as a leftover entry.

// File: rtl/ipi_cmd_pkg.sv
// Package for the interrupt command register: field widths, register
// offsets and the message types shared by the submodules.
// Assumes byte offsets on a 12-bit address and 32-bit data words.
package ipi_cmd_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 12;
    localparam int VEC_W   = 8;
    localparam int DMODE_W = 3;
    localparam int SH_W    = 2;
    localparam int DEST_W  = 8;
    localparam int RRD_W   = 2;

    localparam logic [ADDR_W-1:0] LO_OFF = 12'h300;
    localparam logic [ADDR_W-1:0] HI_OFF = 12'h310;

    // bit positions inside the low word
    localparam int VEC_LSB   = 0;
    localparam int DMODE_LSB = 8;
    localparam int DLOG_BIT  = 11;
    localparam int BUSY_BIT  = 12;
    localparam int LVL_BIT   = 14;
    localparam int TRIG_BIT  = 15;
    localparam int RRD_LSB   = 16;
    localparam int SH_LSB    = 18;
    localparam int DEST_LSB  = DATA_W - DEST_W;

    typedef struct packed {
        logic [SH_W-1:0]    shorthand;
        logic               trig_level;
        logic               level_assert;
        logic               dest_logical;
        logic [DMODE_W-1:0] dmode;
        logic [VEC_W-1:0]   vector;
    } cmd_fields_t;

    typedef struct packed {
        logic [DEST_W-1:0] dest_id;
        cmd_fields_t       fields;
    } ipi_msg_t;
endpackage

// File: rtl/ipi_addr_dec.sv
// Address decoder: turns the register offset and write strobe into
// per-word select and write pulses. Assumes exact offset match.
module ipi_addr_dec
    import ipi_cmd_pkg::*;
#(
    parameter logic [ADDR_W-1:0] LO_ADDR = LO_OFF,
    parameter logic [ADDR_W-1:0] HI_ADDR = HI_OFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    output logic              lo_sel,
    output logic              hi_sel,
    output logic              lo_wr,
    output logic              hi_wr
);
    // compare the offset against both word addresses
    always_comb begin
        lo_sel = (addr == LO_ADDR);
        hi_sel = (addr == HI_ADDR);
        lo_wr  = wr && lo_sel;
        hi_wr  = wr && hi_sel;
    end
endmodule

// File: rtl/ipi_dest_word.sv
// High word: holds the destination ID for the next message.
// Writes are accepted at any time; an in-flight message keeps its
// own copy, so a write here only affects later launches.
module ipi_dest_word
    import ipi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hi_wr,
    input  logic [DEST_W-1:0] wr_dest,
    output logic [DEST_W-1:0] dest_id
);
    // capture the destination ID on a high-word write
    always_ff @(posedge clk) begin
        if (!rst_n)
            dest_id <= '0;
        else if (hi_wr)
            dest_id <= wr_dest;
    end
endmodule

// File: rtl/ipi_cmd_word.sv
// Low word: stores the command fields, owns the delivery-status
// (busy) bit and the sticky refused-write flag. A low write while
// idle launches a message built from the written fields plus the
// current destination ID. Assumes xfer_done only occurs while busy.
module ipi_cmd_word
    import ipi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_wr,
    input  cmd_fields_t       wr_fields,
    input  logic [DEST_W-1:0] dest_id,
    input  logic              xfer_done,
    output cmd_fields_t       cur_fields,
    output logic              busy,
    output logic              busy_err,
    output logic              launch,
    output ipi_msg_t          launch_msg
);
    // a launch is a low write seen while idle
    always_comb begin
        launch             = lo_wr && !busy;
        launch_msg.dest_id = dest_id;
        launch_msg.fields  = wr_fields;
    end

    // keep the last accepted command fields for readback
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur_fields <= '0;
        else if (launch)
            cur_fields <= wr_fields;
    end

    // delivery status: set on launch, cleared by the handshake
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy <= 1'b0;
        else if (launch)
            busy <= 1'b1;
        else if (xfer_done)
            busy <= 1'b0;
    end

    // sticky flag for low writes refused while busy
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_err <= 1'b0;
        else if (lo_wr && busy)
            busy_err <= 1'b1;
    end

    // R3
    launch_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && !busy) |=> busy);

    // R6
    refused_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr && busy) |=> (busy_err && $stable(cur_fields)));

    // R6
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_err |=> busy_err);
endmodule

// File: rtl/ipi_msg_port.sv
// Outbound message stage: registers the launched message and drives
// valid until the receiver takes it. Assumes no launch arrives while
// a message is still held (the command word guarantees this).
module ipi_msg_port
    import ipi_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     launch,
    input  ipi_msg_t launch_msg,
    input  logic     msg_ready,
    output logic     msg_valid,
    output ipi_msg_t msg_q,
    output logic     xfer_done
);
    // handshake completes when both sides agree
    always_comb xfer_done = msg_valid && msg_ready;

    // hold the message payload from launch onward
    always_ff @(posedge clk) begin
        if (!rst_n)
            msg_q <= '0;
        else if (launch)
            msg_q <= launch_msg;
    end

    // valid rises on launch and falls after the handshake
    always_ff @(posedge clk) begin
        if (!rst_n)
            msg_valid <= 1'b0;
        else if (launch)
            msg_valid <= 1'b1;
        else if (xfer_done)
            msg_valid <= 1'b0;
    end

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_q)));

    // R4
    handshake_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_ready) |=> !msg_valid);
endmodule

// File: rtl/ipi_cmd_reg.sv
// Top of the interrupt command register. Connects the decoder, both
// command words and the outbound stage, and forms the read data.
// Assumes one-cycle write strobes and combinational reads.
module ipi_cmd_reg
    import ipi_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic               reg_wr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [RRD_W-1:0]   rrd_status,
    output logic               msg_valid,
    input  logic               msg_ready,
    output logic [VEC_W-1:0]   msg_vector,
    output logic [DMODE_W-1:0] msg_dmode,
    output logic               msg_dest_logical,
    output logic               msg_trig_level,
    output logic               msg_level_assert,
    output logic [SH_W-1:0]    msg_shorthand,
    output logic [DEST_W-1:0]  msg_dest_id,
    output logic               busy_err
);
    logic        lo_sel, hi_sel, lo_wr, hi_wr;
    logic [DEST_W-1:0] dest_id;
    cmd_fields_t wr_fields, cur_fields;
    logic        busy, launch, xfer_done;
    ipi_msg_t    launch_msg, msg_q;
    logic        unused_wbits;

    ipi_addr_dec #(.LO_ADDR(LO_OFF), .HI_ADDR(HI_OFF)) dec_i (
        .addr(reg_addr), .wr(reg_wr),
        .lo_sel(lo_sel), .hi_sel(hi_sel), .lo_wr(lo_wr), .hi_wr(hi_wr)
    );

    // slice the written word into command fields
    always_comb begin
        wr_fields.vector       = reg_wdata[VEC_LSB +: VEC_W];
        wr_fields.dmode        = reg_wdata[DMODE_LSB +: DMODE_W];
        wr_fields.dest_logical = reg_wdata[DLOG_BIT];
        wr_fields.level_assert = reg_wdata[LVL_BIT];
        wr_fields.trig_level   = reg_wdata[TRIG_BIT];
        wr_fields.shorthand    = reg_wdata[SH_LSB +: SH_W];
    end

    assign unused_wbits = ^{reg_wdata[BUSY_BIT], reg_wdata[13],
                            reg_wdata[RRD_LSB +: RRD_W],
                            reg_wdata[DEST_LSB-1:SH_LSB+SH_W]};

    ipi_dest_word dest_i (
        .clk(clk), .rst_n(rst_n), .hi_wr(hi_wr),
        .wr_dest(reg_wdata[DEST_LSB +: DEST_W]), .dest_id(dest_id)
    );

    ipi_cmd_word cmd_i (
        .clk(clk), .rst_n(rst_n), .lo_wr(lo_wr), .wr_fields(wr_fields),
        .dest_id(dest_id), .xfer_done(xfer_done), .cur_fields(cur_fields),
        .busy(busy), .busy_err(busy_err), .launch(launch),
        .launch_msg(launch_msg)
    );

    ipi_msg_port port_i (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_msg(launch_msg),
        .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_q(msg_q),
        .xfer_done(xfer_done)
    );

    // drive the outbound fields from the held message
    always_comb begin
        msg_vector       = msg_q.fields.vector;
        msg_dmode        = msg_q.fields.dmode;
        msg_dest_logical = msg_q.fields.dest_logical;
        msg_trig_level   = msg_q.fields.trig_level;
        msg_level_assert = msg_q.fields.level_assert;
        msg_shorthand    = msg_q.fields.shorthand;
        msg_dest_id      = msg_q.dest_id;
    end

    // assemble read data for the selected word
    always_comb begin
        reg_rdata = '0;
        if (lo_sel) begin
            reg_rdata[VEC_LSB +: VEC_W]     = cur_fields.vector;
            reg_rdata[DMODE_LSB +: DMODE_W] = cur_fields.dmode;
            reg_rdata[DLOG_BIT]             = cur_fields.dest_logical;
            reg_rdata[BUSY_BIT]             = busy;
            reg_rdata[LVL_BIT]              = cur_fields.level_assert;
            reg_rdata[TRIG_BIT]             = cur_fields.trig_level;
            reg_rdata[RRD_LSB +: RRD_W]     = rrd_status;
            reg_rdata[SH_LSB +: SH_W]       = cur_fields.shorthand;
        end else if (hi_sel) begin
            reg_rdata[DEST_LSB +: DEST_W]   = dest_id;
        end
    end

    // R4
    busy_valid_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == msg_valid);
endmodule

// File: tb/ipi_cmd_reg_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: writes push predicted messages into a queue, a
// monitor pops and compares each message at its handshake.
module ipi_cmd_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [1:0]  rrd_status = 2'b00;
    logic        msg_valid;
    logic        msg_ready = 1'b0;
    logic [7:0]  msg_vector;
    logic [2:0]  msg_dmode;
    logic        msg_dest_logical, msg_trig_level, msg_level_assert;
    logic [1:0]  msg_shorthand;
    logic [7:0]  msg_dest_id;
    logic        busy_err;

    int checks = 0;
    int failures = 0;
    int pushed = 0;
    int seen = 0;
    bit done = 0;
    logic [23:0] exp_q[$];

    always #2.5 clk = ~clk;

    ipi_cmd_reg dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rrd_status(rrd_status),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
        .msg_dmode(msg_dmode), .msg_dest_logical(msg_dest_logical),
        .msg_trig_level(msg_trig_level), .msg_level_assert(msg_level_assert),
        .msg_shorthand(msg_shorthand), .msg_dest_id(msg_dest_id),
        .busy_err(busy_err)
    );

    function automatic logic [31:0] mk_lo(input logic [7:0] vec, input logic [2:0] dm,
        input logic dl, input logic lvl, input logic trig, input logic [1:0] sh);
        return (32'(sh) << 18) | (32'(trig) << 15) | (32'(lvl) << 14) |
               (32'(dl) << 11) | (32'(dm) << 8) | 32'(vec);
    endfunction

    function automatic logic [23:0] mk_exp(input logic [7:0] dest, input logic [31:0] lo);
        return {dest, lo[19:18], lo[15], lo[14], lo[11], lo[10:8], lo[7:0]};
    endfunction

    function automatic logic [23:0] actual_msg();
        return {msg_dest_id, msg_shorthand, msg_trig_level, msg_level_assert,
                msg_dest_logical, msg_dmode, msg_vector};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_write(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a; #0.5;
        d = reg_rdata;
    endtask

    // monitor: compare each message as it is handshaken
    always @(negedge clk) begin
        if (rst_n && msg_valid && msg_ready) begin
            seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected message", 32'(actual_msg()), 32'h0);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                check(actual_msg() == e, "R3 message fields", 32'(actual_msg()), 32'(e));
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, lo_a, lo_b;
        logic [7:0] cur_dest;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        check(msg_valid == 1'b0, "R1 valid after reset", 32'(msg_valid), 32'h0);
        check(busy_err == 1'b0, "R1 err after reset", 32'(busy_err), 32'h0);
        do_read(12'h300, rd);
        check(rd == 32'h0, "R1 low word after reset", rd, 32'h0);
        do_read(12'h310, rd);
        check(rd == 32'h0, "R1 high word after reset", rd, 32'h0);

        // R2 destination ID write and readback
        do_write(12'h310, 32'hA5FF_FFFF);
        do_read(12'h310, rd);
        check(rd == 32'hA500_0000, "R2 high word readback", rd, 32'hA500_0000);
        cur_dest = 8'hA5;

        // R3 / R4 launch with ready high
        msg_ready = 1'b1;
        lo_a = mk_lo(8'h3C, 3'd5, 1'b1, 1'b1, 1'b1, 2'b00);
        exp_q.push_back(mk_exp(cur_dest, lo_a)); pushed++;
        do_write(12'h300, lo_a);
        check(msg_valid == 1'b1, "R3 valid after low write", 32'(msg_valid), 32'h1);
        do_read(12'h300, rd);
        check(rd[12] == 1'b1, "R4 busy bit set", 32'(rd[12]), 32'h1);
        check(rd[7:0] == 8'h3C, "R3 vector readback", 32'(rd[7:0]), 32'h3C);
        tick();
        do_read(12'h300, rd);
        check(rd[12] == 1'b0, "R4 busy cleared after handshake", 32'(rd[12]), 32'h0);
        check(msg_valid == 1'b0, "R4 valid cleared after handshake", 32'(msg_valid), 32'h0);

        // R5 / R6 / R7 stalled message
        msg_ready = 1'b0;
        lo_a = mk_lo(8'h9A, 3'd6, 1'b0, 1'b0, 1'b0, 2'b00);
        exp_q.push_back(mk_exp(cur_dest, lo_a)); pushed++;
        do_write(12'h300, lo_a);
        for (int i = 0; i < 4; i++) begin
            check(msg_valid && actual_msg() == mk_exp(cur_dest, lo_a),
                  "R5 stall holds message", 32'(actual_msg()), 32'(mk_exp(cur_dest, lo_a)));
            tick();
        end
        lo_b = mk_lo(8'h55, 3'd1, 1'b1, 1'b1, 1'b1, 2'b11);
        do_write(12'h300, lo_b);
        check(busy_err == 1'b1, "R6 error flag on busy write", 32'(busy_err), 32'h1);
        do_read(12'h300, rd);
        check(rd[7:0] == 8'h9A, "R6 low word unchanged", 32'(rd[7:0]), 32'h9A);
        do_write(12'h310, 32'h1100_0000);
        check(msg_dest_id == 8'hA5, "R7 in-flight dest kept", 32'(msg_dest_id), 32'hA5);
        cur_dest = 8'h11;
        msg_ready = 1'b1;
        tick(); tick();
        check(msg_valid == 1'b0, "R6 no second message", 32'(msg_valid), 32'h0);
        check(busy_err == 1'b1, "R6 error flag sticky", 32'(busy_err), 32'h1);

        // R7 / R9 shorthand sweep with new destination
        for (int s = 0; s < 4; s++) begin
            lo_a = mk_lo(8'(8'h40 + s), 3'(s), s[0], 1'b0, s[1], 2'(s));
            exp_q.push_back(mk_exp(cur_dest, lo_a)); pushed++;
            do_write(12'h300, lo_a);
            check(msg_shorthand == 2'(s), "R9 shorthand passed", 32'(msg_shorthand), 32'(s));
            check(msg_dest_id == 8'h11, "R7 next message dest", 32'(msg_dest_id), 32'h11);
            tick();
        end

        // R8 remote-read status mirror
        rrd_status = 2'b10;
        do_read(12'h300, rd);
        check(rd[17:16] == 2'b10, "R8 status mirror", 32'(rd[17:16]), 32'h2);
        lo_a = mk_lo(8'h07, 3'd0, 1'b0, 1'b1, 1'b0, 2'b01) | 32'h0001_0000;
        exp_q.push_back(mk_exp(cur_dest, lo_a)); pushed++;
        do_write(12'h300, lo_a);
        do_read(12'h300, rd);
        check(rd[17:16] == 2'b10, "R8 status not writable", 32'(rd[17:16]), 32'h2);
        rrd_status = 2'b01;
        do_read(12'h300, rd);
        check(rd[17:16] == 2'b01, "R8 status in progress", 32'(rd[17:16]), 32'h1);
        tick(); tick();

        // R10 unmapped write
        do_write(12'h320, 32'hFFFF_FFFF);
        check(msg_valid == 1'b0, "R10 no launch on other offset", 32'(msg_valid), 32'h0);
        do_read(12'h320, rd);
        check(rd == 32'h0, "R10 other offset reads zero", rd, 32'h0);
        do_read(12'h310, rd);
        check(rd == 32'h1100_0000, "R10 high word unchanged", rd, 32'h1100_0000);
        do_read(12'h300, rd);
        check(rd[7:0] == 8'h07, "R10 low word unchanged", 32'(rd[7:0]), 32'h07);

        repeat (3) tick();
        check(exp_q.size() == 0, "R3 all messages delivered", 32'(exp_q.size()), 32'h0);
        check(seen == pushed, "R6 message count", 32'(seen), 32'(pushed));

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule